// File: doc/BRIEF.md
# ACPI Power Management Event Controller

This block holds the fixed-function power management registers of a platform controller. Firmware and the operating system reach it through a 64-byte I/O window. The window carries a free-running PM timer, a 16-bit event status register, a 16-bit event enable register and a 16-bit control register. A separate two-byte APM port holds a command byte and a scratch byte. The block raises a level-sensitive SCI whenever an enabled event is pending.

A sleep command is a control write with the sleep-enable bit set. It becomes either a one-cycle power-off request or a one-cycle suspend/resume reset request. For the suspend/resume case the block first presets the resume and power-button status bits, so that software sees the wake source. A write to the APM command port can raise a one-cycle SMI request. The value written there can also switch the SCI-enable control bit. The PM timer advances on a clock-enable strobe at the PM frequency of 3.579545 MHz, which the surrounding logic derives from the system clock.

Top module: `pm_event_ctrl`

## Requirements
- R1: After reset, the status, enable, control, APM command and APM scratch registers and the timer all read zero. The outputs sci, shutdownReq, resetReq and smiReq are low.
- R2: The timer is TMR_W bits wide (24 by default). It increments by one on each clock edge where tickEn is high, holds otherwise, and wraps to zero. A read at offset 0x08 returns it zero-extended to 32 bits.
- R3: Status bit 0 (timer overflow) sets whenever the timer's most significant bit changes value. That happens at each multiple of half the timer range. A hardware set wins over a software clear in the same cycle.
- R4: A write to offset 0x00 clears each status bit whose written bit is 1 and leaves the others unchanged. Offset 0x00 reads the status register.
- R5: Offset 0x02 reads and writes the 16-bit enable register. Offset 0x04 reads and writes the 16-bit control register, except that bit 13 (sleep enable) is never stored and always reads 0.
- R6: sci is high exactly when (status AND enable) has bit 0, 5, 8 or 10 set. Any other common bit, such as bit 15, does not raise it. It follows the registers from the cycle after a change.
- R7: A control write with bit 13 set and bits 12:10 equal to 0 pulses shutdownReq high for exactly one cycle.
- R8: A control write with bit 13 set and bits 12:10 equal to 1 sets status bits 15 and 8 and pulses resetReq high for one cycle. Any other sleep type produces no pulse and no status change.
- R9: An APM write at apmAddr 0 stores the command byte. Value 0xF1 also sets control bit 0 and value 0xF0 clears it. apmAddr 1 is a plain scratch byte. apmRdata returns the byte that apmAddr selects.
- R10: smiReq pulses for one cycle after an APM command write (apmAddr 0) only while smiEnable is high.
- R11: A pwrBtn pulse sets status bit 8 only when enable bit 8 is set. Otherwise the status is unchanged.
- R12: Offsets in the window other than 0x00, 0x02, 0x04 and 0x08 read zero and ignore writes. A write to 0x08 is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | PM-frequency clock-enable strobe for the timer |
| busAddr | input | 6 | Byte offset within the PM window |
| busWr | input | 1 | Write strobe for the PM window |
| busWdata | input | 16 | Write data for the PM window |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| apmWr | input | 1 | Write strobe for the APM port |
| apmAddr | input | 1 | APM port select: 0 command, 1 scratch |
| apmWdata | input | 8 | APM write data |
| apmRdata | output | 8 | APM read data for apmAddr |
| smiEnable | input | 1 | Allows APM command writes to request an SMI |
| pwrBtn | input | 1 | Power-button event pulse |
| sci | output | 1 | Level SCI interrupt |
| shutdownReq | output | 1 | One-cycle power-off request |
| resetReq | output | 1 | One-cycle suspend/resume reset request |
| smiReq | output | 1 | One-cycle SMI request |

## Verification
The checker watches several properties on every cycle. It confirms that the timer holds without a strobe and that every change of its top bit leaves the overflow status set. It confirms that the sleep-enable bit never appears in control and that the shutdown and SMI pulses last exactly one cycle. It also checks that an SMI request only follows an enabled command write, that a resume request always comes with its preset status bits, and that an enabled power-button pulse lands in status. The bench scenarios cover the rest. Those are the exact overflow points and the wrap, write-one-to-clear against a mix of random masks, and the SCI mask across its four bits and a non-mask bit. They also cover the sleep-type decode, the 0xF1/0xF0 command effect on control, and the silence of unmapped offsets.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam logic [5:0] OFS_STS = 6'h00;
  localparam logic [5:0] OFS_EN  = 6'h02;
  localparam logic [5:0] OFS_CTL = 6'h04;
  localparam logic [5:0] OFS_TMR = 6'h08;

  localparam int SLEEP_EN_BIT = 13;
  localparam logic [15:0] SCI_MASK    = 16'h0521;
  localparam logic [15:0] RESUME_SET  = 16'h8100;
  localparam int BTN_BIT = 8;
  localparam int OVF_BIT = 0;

  localparam logic [7:0] CMD_ACPI_ON  = 8'hF1;
  localparam logic [7:0] CMD_ACPI_OFF = 8'hF0;

  typedef struct packed {
    logic wrSts;
    logic wrEn;
    logic wrCtl;
    logic sleepResume;
    logic apmCmd;
    logic apmScr;
    logic acpiOn;
    logic acpiOff;
  } pmStrobe_t;
endpackage

// File: rtl/pm_timer.sv
module pm_timer #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  output logic [TMR_W-1:0] count,
  output logic             ovf
);
  localparam int LOW_W = TMR_W - 1;

  // The top bit flips on the next tick exactly when every lower bit is one.
  assign ovf = tickEn && (&count[LOW_W-1:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= '0;
    else if (tickEn) count <= count + 1'b1;
  end
endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [5:0]  busAddr,
  input  logic        busWr,
  input  logic [15:0] busWdata,
  input  logic        apmWr,
  input  logic        apmAddr,
  input  logic [7:0]  apmWdata,
  input  logic        smiEnable,
  output pmStrobe_t   strobe,
  output logic        shutdownReq,
  output logic        resetReq,
  output logic        smiReq
);
  logic       sleepCmd;
  logic [2:0] sleepType;
  logic       sleepOff;

  assign sleepType = busWdata[12:10];

  always_comb begin
    strobe = '0;
    strobe.wrSts = busWr && (busAddr == OFS_STS);
    strobe.wrEn  = busWr && (busAddr == OFS_EN);
    strobe.wrCtl = busWr && (busAddr == OFS_CTL);
    strobe.apmCmd = apmWr && !apmAddr;
    strobe.apmScr = apmWr && apmAddr;
    strobe.acpiOn  = strobe.apmCmd && (apmWdata == CMD_ACPI_ON);
    strobe.acpiOff = strobe.apmCmd && (apmWdata == CMD_ACPI_OFF);
    sleepCmd = strobe.wrCtl && busWdata[SLEEP_EN_BIT];
    sleepOff = sleepCmd && (sleepType == 3'd0);
    strobe.sleepResume = sleepCmd && (sleepType == 3'd1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shutdownReq <= 1'b0;
      resetReq    <= 1'b0;
      smiReq      <= 1'b0;
    end else begin
      shutdownReq <= sleepOff;
      resetReq    <= strobe.sleepResume;
      smiReq      <= strobe.apmCmd && smiEnable;
    end
  end
endmodule

// File: rtl/pm_datapath.sv
module pm_datapath
  import pm_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  pmStrobe_t        strobe,
  input  logic [5:0]       busAddr,
  input  logic [15:0]      busWdata,
  input  logic             apmAddr,
  input  logic [7:0]       apmWdata,
  input  logic             pwrBtn,
  input  logic             ovf,
  input  logic [TMR_W-1:0] count,
  output logic [31:0]      busRdata,
  output logic [7:0]       apmRdata,
  output logic             sci,
  output logic [15:0]      stsVal,
  output logic [15:0]      enVal,
  output logic [15:0]      ctlVal
);
  logic [15:0] stsQ, enQ, ctlQ;
  logic [7:0]  apmCmdQ, apmScrQ;
  logic [15:0] setMask, clrMask, ctlNext;

  always_comb begin
    setMask = '0;
    setMask[OVF_BIT] = ovf;
    setMask[BTN_BIT] = pwrBtn && enQ[BTN_BIT];
    if (strobe.sleepResume) setMask = setMask | RESUME_SET;
    clrMask = strobe.wrSts ? busWdata : 16'h0000;
  end

  always_comb begin
    ctlNext = ctlQ;
    if (strobe.wrCtl) begin
      ctlNext = busWdata;
      ctlNext[SLEEP_EN_BIT] = 1'b0;
    end
    if (strobe.acpiOn)  ctlNext[0] = 1'b1;
    if (strobe.acpiOff) ctlNext[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stsQ    <= '0;
      enQ     <= '0;
      ctlQ    <= '0;
      apmCmdQ <= '0;
      apmScrQ <= '0;
    end else begin
      stsQ <= (stsQ & ~clrMask) | setMask;
      if (strobe.wrEn) enQ <= busWdata;
      ctlQ <= ctlNext;
      if (strobe.apmCmd) apmCmdQ <= apmWdata;
      if (strobe.apmScr) apmScrQ <= apmWdata;
    end
  end

  always_comb begin
    unique case (busAddr)
      OFS_STS: busRdata = {16'h0000, stsQ};
      OFS_EN:  busRdata = {16'h0000, enQ};
      OFS_CTL: busRdata = {16'h0000, ctlQ};
      OFS_TMR: busRdata = 32'(count);
      default: busRdata = 32'h0;
    endcase
  end

  assign apmRdata = apmAddr ? apmScrQ : apmCmdQ;
  assign sci      = |(stsQ & enQ & SCI_MASK);
  assign stsVal   = stsQ;
  assign enVal    = enQ;
  assign ctlVal   = ctlQ;
endmodule

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl
  import pm_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic [5:0]  busAddr,
  input  logic        busWr,
  input  logic [15:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        apmWr,
  input  logic        apmAddr,
  input  logic [7:0]  apmWdata,
  output logic [7:0]  apmRdata,
  input  logic        smiEnable,
  input  logic        pwrBtn,
  output logic        sci,
  output logic        shutdownReq,
  output logic        resetReq,
  output logic        smiReq
);
  pmStrobe_t        strobe;
  logic [TMR_W-1:0] tmrVal;
  logic             ovf;
  logic [15:0]      stsVal, enVal, ctlVal;

  pm_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .count(tmrVal), .ovf(ovf)
  );

  pm_ctrl u_ctl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .apmWr(apmWr), .apmAddr(apmAddr),
    .apmWdata(apmWdata), .smiEnable(smiEnable), .strobe(strobe),
    .shutdownReq(shutdownReq), .resetReq(resetReq), .smiReq(smiReq)
  );

  pm_datapath #(.TMR_W(TMR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr),
    .busWdata(busWdata), .apmAddr(apmAddr), .apmWdata(apmWdata),
    .pwrBtn(pwrBtn), .ovf(ovf), .count(tmrVal), .busRdata(busRdata),
    .apmRdata(apmRdata), .sci(sci), .stsVal(stsVal), .enVal(enVal),
    .ctlVal(ctlVal)
  );
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
  parameter int TMR_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic             apmWr,
  input logic             apmAddr,
  input logic             smiEnable,
  input logic             pwrBtn,
  input logic             shutdownReq,
  input logic             resetReq,
  input logic             smiReq,
  input logic [15:0]      stsVal,
  input logic [15:0]      enVal,
  input logic [15:0]      ctlVal,
  input logic [TMR_W-1:0] tmrVal
);
  localparam int TOP = TMR_W - 1;

  a_r2_timer_hold: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(tmrVal));

  a_r3_ovf_sets: assert property (@(posedge clk) disable iff (!rstN)
    (tmrVal[TOP] != $past(tmrVal[TOP])) |-> stsVal[0]);

  a_r5_sleep_bit_clear: assert property (@(posedge clk) disable iff (!rstN)
    !ctlVal[13]);

  a_r7_shutdown_pulse: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |=> !shutdownReq);

  a_r8_reset_sets_status: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (stsVal[15] && stsVal[8]));

  a_r10_smi_gated: assert property (@(posedge clk) disable iff (!rstN)
    $rose(smiReq) |-> $past(apmWr && !apmAddr && smiEnable));

  a_r10_smi_pulse: assert property (@(posedge clk) disable iff (!rstN)
    smiReq |=> !(smiReq && !$past(apmWr && !apmAddr && smiEnable, 1)));

  a_r11_button_lands: assert property (@(posedge clk) disable iff (!rstN)
    (pwrBtn && enVal[8]) |=> stsVal[8]);
endmodule

bind pm_event_ctrl pm_checker #(.TMR_W(TMR_W)) u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .apmWr(apmWr), .apmAddr(apmAddr),
  .smiEnable(smiEnable), .pwrBtn(pwrBtn), .shutdownReq(shutdownReq),
  .resetReq(resetReq), .smiReq(smiReq), .stsVal(stsVal), .enVal(enVal),
  .ctlVal(ctlVal), .tmrVal(tmrVal)
);

// File: tb/sim_pm_event_ctrl.sv
`timescale 1ns/1ps
module sim_pm_event_ctrl;
  localparam int TW = 10;
  localparam logic [15:0] MASK = 16'h0521;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [15:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        apmWr = 1'b0;
  logic        apmAddr = 1'b0;
  logic [7:0]  apmWdata = '0;
  logic [7:0]  apmRdata;
  logic        smiEnable = 1'b0;
  logic        pwrBtn = 1'b0;
  logic        sci, shutdownReq, resetReq, smiReq;

  int errors = 0;
  int checks = 0;
  logic [15:0] stsM;
  logic [31:0] rd;

  always #4 clk = ~clk;

  pm_event_ctrl #(.TMR_W(TW)) u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .apmWr(apmWr), .apmAddr(apmAddr),
    .apmWdata(apmWdata), .apmRdata(apmRdata), .smiEnable(smiEnable),
    .pwrBtn(pwrBtn), .sci(sci), .shutdownReq(shutdownReq),
    .resetReq(resetReq), .smiReq(smiReq)
  );

  function automatic logic expSci(logic [15:0] s, logic [15:0] e);
    return |(s & e & MASK);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdReg(logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    busAddr = a;
    #1 v = busRdata;
  endtask

  task automatic apmW(logic a, logic [7:0] d);
    @(negedge clk);
    apmAddr = a; apmWdata = d; apmWr = 1'b1;
    @(negedge clk);
    apmWr = 1'b0;
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic button();
    @(negedge clk);
    pwrBtn = 1'b1;
    @(negedge clk);
    pwrBtn = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] seedv;
    seedv = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    // R1: reset state, probed while reset is still asserted
    chk("R1 sci", {31'b0, sci}, 32'd0);
    chk("R1 pulses", {29'b0, shutdownReq, resetReq, smiReq}, 32'd0);
    rstN = 1'b1;
    rdReg(6'h00, rd); chk("R1 status", rd, 32'h0);
    rdReg(6'h02, rd); chk("R1 enable", rd, 32'h0);
    rdReg(6'h04, rd); chk("R1 control", rd, 32'h0);
    rdReg(6'h08, rd); chk("R1 timer", rd, 32'h0);
    #1 chk("R1 apm cmd", {24'b0, apmRdata}, 32'h0);

    // R2 / R3: counting and overflow at the top-bit boundaries (TW=10)
    ticks(100);
    rdReg(6'h08, rd); chk("R2 count 100", rd, 32'd100);
    ticks(411);
    rdReg(6'h00, rd); chk("R3 no ovf at 511", rd, 32'h0);
    ticks(1);
    rdReg(6'h00, rd); chk("R3 ovf at 512", rd, 32'h1);
    rdReg(6'h08, rd); chk("R2 count 512", rd, 32'd512);
    wr(6'h00, 16'h0001);
    rdReg(6'h00, rd); chk("R4 clear ovf", rd, 32'h0);
    ticks(512);
    rdReg(6'h08, rd); chk("R2 wrap to zero", rd, 32'd0);
    rdReg(6'h00, rd); chk("R3 ovf on wrap", rd, 32'h1);
    wr(6'h08, 16'h1234);
    rdReg(6'h08, rd); chk("R12 timer write ignored", rd, 32'd0);

    // R6: overflow with its enable raises sci
    wr(6'h02, 16'h0001);
    #1 chk("R6 sci bit0", {31'b0, sci}, 32'd1);
    wr(6'h00, 16'hFFFF);
    #1 chk("R6 sci drops after clear", {31'b0, sci}, 32'd0);

    // R5: enable / control storage
    wr(6'h02, 16'hA5C3);
    rdReg(6'h02, rd); chk("R5 enable readback", rd, 32'hA5C3);
    wr(6'h04, 16'h3C02 & ~16'h2000 | 16'h0002);
    rdReg(6'h04, rd); chk("R5 control readback", rd, 32'h1C02);

    // R8 other sleep type: nothing happens
    wr(6'h00, 16'hFFFF);
    wr(6'h04, 16'h2800);
    chk("R8 type2 no pulse", {30'b0, shutdownReq, resetReq}, 32'd0);
    rdReg(6'h04, rd); chk("R5 sleep bit dropped", rd, 32'h0800);
    rdReg(6'h00, rd); chk("R8 type2 status unchanged", rd, 32'h0);

    // R8: suspend with resume
    wr(6'h02, 16'h0000);
    wr(6'h04, 16'h2400);
    chk("R8 reset pulse", {31'b0, resetReq}, 32'd1);
    @(negedge clk);
    chk("R8 reset pulse ends", {31'b0, resetReq}, 32'd0);
    rdReg(6'h00, rd); chk("R8 resume status", rd, 32'h8100);
    wr(6'h02, 16'h8000);
    #1 chk("R6 bit15 no sci", {31'b0, sci}, 32'd0);
    wr(6'h02, 16'h0100);
    #1 chk("R6 bit8 sci", {31'b0, sci}, 32'd1);

    // R7: power off
    wr(6'h04, 16'h2000);
    chk("R7 shutdown pulse", {31'b0, shutdownReq}, 32'd1);
    chk("R7 no reset pulse", {31'b0, resetReq}, 32'd0);
    @(negedge clk);
    chk("R7 shutdown pulse ends", {31'b0, shutdownReq}, 32'd0);

    // R11: power button gating
    wr(6'h00, 16'hFFFF);
    wr(6'h02, 16'h0000);
    button();
    rdReg(6'h00, rd); chk("R11 button masked", rd, 32'h0);
    wr(6'h02, 16'h0100);
    button();
    rdReg(6'h00, rd); chk("R11 button lands", rd, 32'h0100);
    #1 chk("R11 sci from button", {31'b0, sci}, 32'd1);

    // R9 / R10: APM port
    smiEnable = 1'b0;
    apmW(1'b0, 8'hF1);
    chk("R10 no smi when disabled", {31'b0, smiReq}, 32'd0);
    rdReg(6'h04, rd); chk("R9 acpi on", rd, 32'h0001);
    smiEnable = 1'b1;
    apmW(1'b0, 8'hF0);
    chk("R10 smi pulse", {31'b0, smiReq}, 32'd1);
    @(negedge clk);
    chk("R10 smi ends", {31'b0, smiReq}, 32'd0);
    rdReg(6'h04, rd); chk("R9 acpi off", rd, 32'h0000);
    apmW(1'b1, 8'h5A);
    chk("R10 scratch no smi", {31'b0, smiReq}, 32'd0);
    #1 chk("R9 scratch readback", {24'b0, apmRdata}, 32'h5A);
    apmAddr = 1'b0;
    #1 chk("R9 cmd readback", {24'b0, apmRdata}, 32'hF0);
    apmW(1'b0, 8'h33);
    rdReg(6'h04, rd); chk("R9 other cmd keeps control", rd, 32'h0000);
    smiEnable = 1'b0;

    // R12: unmapped offsets
    wr(6'h06, 16'hFFFF);
    rdReg(6'h06, rd); chk("R12 read zero 0x06", rd, 32'h0);
    rdReg(6'h3E, rd); chk("R12 read zero 0x3E", rd, 32'h0);
    rdReg(6'h02, rd); chk("R12 enable untouched", rd, 32'h0100);

    // Random mix: R4 / R6 / R11 against a model
    wr(6'h00, 16'hFFFF);
    stsM = 16'h0;
    for (int i = 0; i < 60; i++) begin
      logic [15:0] e, c;
      e = 16'($urandom);
      wr(6'h02, e);
      if ($urandom % 2 == 1) begin
        button();
        if (e[8]) stsM[8] = 1'b1;
      end
      if ($urandom % 3 == 0) begin
        c = 16'($urandom);
        wr(6'h00, c);
        stsM = stsM & ~c;
      end
      rdReg(6'h00, rd); chk("R4 R11 random status", rd, {16'h0, stsM});
      #1 chk("R6 random sci", {31'b0, sci}, {31'b0, expSci(stsM, e)});
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule